// File: doc/BRIEF.md
# Flag Condition Branch Evaluator

This block resolves control-transfer instructions in the execute stage of a word-addressed processor. It takes the decoded opcode, the 4-bit register/condition field, the contents of the selected register, the zero, negative and error flags, the resolved operand value and the current program counter. One cycle after an input is marked valid, it reports whether the branch is taken and which address the program counter must load next.

Four opcodes test conditions. One branches unconditionally. Three test the sign or zero state of a general register. One reads the 4-bit field as a selector over seven flag tests rather than as a register number. Selector values outside that set never branch and raise an illegal-condition output. Any other opcode goes to the next sequential word. The block does not handle stack traffic for call and return, and it does not produce flags.

Top module: `brEval`

## Requirements
- R1: While `rstN` is low, and on the first clock after it rises, `outValid`, `taken` and `illegalCond` are 0 and `nextPc` is 0.
- R2: A request sampled with `inValid` high at a rising edge produces exactly one result, with `outValid` high, in the following cycle. `outValid` is low in every other cycle.
- R3: Opcode 25 is always taken, whatever the flags and the register value.
- R4: Opcode 26 is taken exactly when `regValue` equals zero.
- R5: Opcode 27 is taken exactly when `regValue` is greater than zero as a signed 32-bit number. Zero and 0x80000000 are not taken.
- R6: Opcode 28 is taken exactly when bit 31 of `regValue` is set.
- R7: For opcode 29, selector 0 is taken when Z is 1, and selector 1 is taken when Z is 0.
- R8: For opcode 29, selector 2 is taken when N is 1, and selector 3 is taken when Z or N is 1.
- R9: For opcode 29, selector 4 is taken when Z and N are both 0, and selector 5 is taken when N is 0.
- R10: For opcode 29, selector 6 is taken when E is 1. The register value plays no part in any opcode-29 decision.
- R11: For opcode 29, selectors 7 to 15 are never taken and drive `illegalCond` to 1 with that result, for any flag values. `illegalCond` is 0 for every other request.
- R12: A taken result gives `nextPc` equal to the sampled `operand`. A not-taken result gives `nextPc` equal to the sampled `curPc` plus one, modulo 2^32, so 0xFFFFFFFF wraps to 0.
- R13: Every opcode other than 25 to 29 is not taken, with `illegalCond` 0, whatever the field, flags and register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Marks the inputs as a request in this cycle |
| opcode | input | 7 | Instruction opcode |
| fieldSel | input | 4 | Register-number field, used as condition selector for opcode 29 |
| regValue | input | 32 | Contents of the register named by the field |
| flagZ | input | 1 | Zero flag |
| flagN | input | 1 | Negative flag |
| flagE | input | 1 | Error flag |
| operand | input | 32 | Resolved operand value, the branch target |
| curPc | input | 32 | Address of the current instruction |
| outValid | output | 1 | Result present this cycle |
| taken | output | 1 | Branch taken |
| nextPc | output | 32 | Next program counter |
| illegalCond | output | 1 | Opcode 29 with an undefined selector |

## Verification
The bench runs every opcode-29 selector against all eight flag combinations, with unrelated register values. A design that decoded a selector wrongly, dropped the error-flag test or let the register leak into a flag decision would mismatch there. It also checks that selectors 7 to 15 neither branch nor stay silent. Register tests are driven at 0, 1, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF, which exposes a positive test that treats the sign bit as magnitude or counts zero as positive. Fall-through at PC 0xFFFFFFFF checks the wrap to 0. Opcodes just outside the branch range (24, 30) and gaps between requests catch decoders with an off-by-one range and results emitted without a request.

// File: rtl/brEval_pkg.sv
package brEval_pkg;

  localparam int OP_W = 7;

  localparam logic [OP_W-1:0] OP_JUMP = 7'd25;
  localparam logic [OP_W-1:0] OP_JZER = 7'd26;
  localparam logic [OP_W-1:0] OP_JPOS = 7'd27;
  localparam logic [OP_W-1:0] OP_JNEG = 7'd28;
  localparam logic [OP_W-1:0] OP_JFLG = 7'd29;

  localparam int NUM_COND = 7;

  typedef enum logic [2:0] {
    CC_ZSET    = 3'd0,
    CC_ZCLR    = 3'd1,
    CC_NSET    = 3'd2,
    CC_ZORN    = 3'd3,
    CC_NEITHER = 3'd4,
    CC_NCLR    = 3'd5,
    CC_ESET    = 3'd6,
    CC_NONE    = 3'd7
  } condSel_e;

  typedef struct packed {
    logic     doUncond;
    logic     doZero;
    logic     doPos;
    logic     doNeg;
    logic     doFlag;
    logic     badCond;
    condSel_e condSel;
  } brCtrl_t;

endpackage

// File: rtl/brEvalCtrl.sv
module brEvalCtrl
  import brEval_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic [OP_W-1:0]  opcode,
  input  logic [SEL_W-1:0] fieldSel,
  output brCtrl_t          ctrl
);

  localparam logic [SEL_W-1:0] LAST_COND = SEL_W'(NUM_COND - 1);

  always_comb begin
    ctrl = '{doUncond: 1'b0, doZero: 1'b0, doPos: 1'b0, doNeg: 1'b0,
             doFlag: 1'b0, badCond: 1'b0, condSel: CC_NONE};
    unique case (opcode)
      OP_JUMP: ctrl.doUncond = 1'b1;
      OP_JZER: ctrl.doZero   = 1'b1;
      OP_JPOS: ctrl.doPos    = 1'b1;
      OP_JNEG: ctrl.doNeg    = 1'b1;
      OP_JFLG: begin
        if (fieldSel > LAST_COND) begin
          ctrl.badCond = 1'b1;
        end else begin
          ctrl.doFlag  = 1'b1;
          ctrl.condSel = condSel_e'(fieldSel[2:0]);
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/brEvalPath.sv
module brEvalPath
  import brEval_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  brCtrl_t           ctrl,
  input  logic [DATA_W-1:0] regValue,
  input  logic              flagZ,
  input  logic              flagN,
  input  logic              flagE,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] curPc,
  output logic              outValid,
  output logic              taken,
  output logic [DATA_W-1:0] nextPc,
  output logic              illegalCond
);

  localparam int NUM_SLOT = 2 ** $bits(condSel_e);

  logic                regZero;
  logic                regNeg;
  logic                regPos;
  logic [NUM_SLOT-1:0] condVec;
  logic                flagHit;
  logic                takeNow;
  logic [DATA_W-1:0]   seqPc;
  logic [DATA_W-1:0]   pcNext;

  assign regZero = (regValue == '0);
  assign regNeg  = regValue[DATA_W-1];
  assign regPos  = !regZero && !regNeg;

  // One test per selector slot; unused slots never match
  genvar gi;
  generate
    for (gi = 0; gi < NUM_SLOT; gi++) begin : g_cond
      if (gi == int'(CC_ZSET)) begin : g_zs
        assign condVec[gi] = flagZ;
      end else if (gi == int'(CC_ZCLR)) begin : g_zc
        assign condVec[gi] = !flagZ;
      end else if (gi == int'(CC_NSET)) begin : g_ns
        assign condVec[gi] = flagN;
      end else if (gi == int'(CC_ZORN)) begin : g_zn
        assign condVec[gi] = flagZ || flagN;
      end else if (gi == int'(CC_NEITHER)) begin : g_nn
        assign condVec[gi] = !flagZ && !flagN;
      end else if (gi == int'(CC_NCLR)) begin : g_nc
        assign condVec[gi] = !flagN;
      end else if (gi == int'(CC_ESET)) begin : g_es
        assign condVec[gi] = flagE;
      end else begin : g_off
        assign condVec[gi] = 1'b0;
      end
    end
  endgenerate

  assign flagHit = condVec[ctrl.condSel];

  assign takeNow = ctrl.doUncond
                || (ctrl.doZero && regZero)
                || (ctrl.doPos  && regPos)
                || (ctrl.doNeg  && regNeg)
                || (ctrl.doFlag && flagHit);

  assign seqPc  = curPc + DATA_W'(1);
  assign pcNext = takeNow ? operand : seqPc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      taken       <= 1'b0;
      nextPc      <= '0;
      illegalCond <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        taken       <= takeNow;
        nextPc      <= pcNext;
        illegalCond <= ctrl.badCond;
      end
    end
  end

endmodule

// File: rtl/brEval.sv
module brEval
  import brEval_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [OP_W-1:0]   opcode,
  input  logic [SEL_W-1:0]  fieldSel,
  input  logic [DATA_W-1:0] regValue,
  input  logic              flagZ,
  input  logic              flagN,
  input  logic              flagE,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] curPc,
  output logic              outValid,
  output logic              taken,
  output logic [DATA_W-1:0] nextPc,
  output logic              illegalCond
);

  brCtrl_t ctrl;

  brEvalCtrl #(.SEL_W(SEL_W)) u_ctrl (
    .opcode  (opcode),
    .fieldSel(fieldSel),
    .ctrl    (ctrl)
  );

  brEvalPath #(.DATA_W(DATA_W)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .ctrl       (ctrl),
    .regValue   (regValue),
    .flagZ      (flagZ),
    .flagN      (flagN),
    .flagE      (flagE),
    .operand    (operand),
    .curPc      (curPc),
    .outValid   (outValid),
    .taken      (taken),
    .nextPc     (nextPc),
    .illegalCond(illegalCond)
  );

endmodule

// File: rtl/brEvalChk.sv
module brEvalChk
  import brEval_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [OP_W-1:0]   opcode,
  input logic [DATA_W-1:0] regValue,
  input logic [DATA_W-1:0] operand,
  input logic [DATA_W-1:0] curPc,
  input logic              outValid,
  input logic              taken,
  input logic [DATA_W-1:0] nextPc,
  input logic              illegalCond
);

  p_one_result_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(inValid));

  p_always_jump_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(opcode) == OP_JUMP) |-> taken);

  p_sign_test_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(opcode) == OP_JNEG) |-> (taken == $past(regValue[DATA_W-1])));

  p_bad_never_taken_r11: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && illegalCond) |-> (!taken && $past(opcode) == OP_JFLG));

  p_target_r12: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && taken) |-> (nextPc == $past(operand)));

  p_fallthru_r12: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !taken) |-> (nextPc == $past(curPc) + DATA_W'(1)));

  p_non_branch_r13: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && ($past(opcode) < OP_JUMP || $past(opcode) > OP_JFLG))
      |-> (!taken && !illegalCond));

endmodule

bind brEval brEvalChk #(.DATA_W(DATA_W)) u_brEvalChk (.*);

// File: tb/test_brEval.sv
module test_brEval;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [6:0]  opcode = '0;
  logic [3:0]  fieldSel = '0;
  logic [31:0] regValue = '0;
  logic        flagZ = 1'b0;
  logic        flagN = 1'b0;
  logic        flagE = 1'b0;
  logic [31:0] operand = '0;
  logic [31:0] curPc = '0;
  logic        outValid;
  logic        taken;
  logic [31:0] nextPc;
  logic        illegalCond;

  int nCompared = 0;
  int nBad = 0;
  bit finished = 0;

  typedef struct {
    logic        tk;
    logic [31:0] pc;
    logic        bad;
    string       req;
  } exp_t;

  exp_t sbQ[$];

  always #10 clk = ~clk;

  brEval i_brEval (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode),
    .fieldSel(fieldSel), .regValue(regValue), .flagZ(flagZ), .flagN(flagN),
    .flagE(flagE), .operand(operand), .curPc(curPc), .outValid(outValid),
    .taken(taken), .nextPc(nextPc), .illegalCond(illegalCond)
  );

  function automatic exp_t model(input logic [6:0] op, input logic [3:0] sel,
                                 input logic [31:0] rv, input logic z, n, e,
                                 input logic [31:0] tgt, input logic [31:0] pc,
                                 input string req);
    exp_t r;
    logic go;
    go = 1'b0;
    r.bad = 1'b0;
    if (op == 7'd25) go = 1'b1;
    else if (op == 7'd26) go = (rv == 32'd0);
    else if (op == 7'd27) go = ($signed(rv) > 0);
    else if (op == 7'd28) go = ($signed(rv) < 0);
    else if (op == 7'd29) begin
      case (sel)
        4'd0: go = z;
        4'd1: go = ~z;
        4'd2: go = n;
        4'd3: go = z | n;
        4'd4: go = ~(z | n);
        4'd5: go = ~n;
        4'd6: go = e;
        default: r.bad = 1'b1;
      endcase
    end
    r.tk  = go;
    r.pc  = go ? tgt : pc + 32'd1;
    r.req = req;
    return r;
  endfunction

  task automatic check1(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
    nCompared++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [6:0] op, input logic [3:0] sel,
                      input logic [31:0] rv, input logic z, n, e,
                      input logic [31:0] tgt, input logic [31:0] pc,
                      input string req);
    @(negedge clk);
    opcode = op; fieldSel = sel; regValue = rv;
    flagZ = z; flagN = n; flagE = e; operand = tgt; curPc = pc;
    inValid = 1'b1;
    sbQ.push_back(model(op, sel, rv, z, n, e, tgt, pc, req));
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      opcode = 7'd25;
    end
  endtask

  task automatic wrapUp();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nBad);
      $finish;
    end
  endtask

  // Monitor: one result per request, sampled mid-cycle
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (sbQ.size() == 0) begin
        check1("R2", "unexpected outValid", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sbQ.pop_front();
        check1(e.req, "taken", {31'd0, taken}, {31'd0, e.tk});
        check1(e.req, "nextPc", nextPc, e.pc);
        check1(e.req, "illegalCond", {31'd0, illegalCond}, {31'd0, e.bad});
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    nCompared++;
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    wrapUp();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check1("R1", "outValid", {31'd0, outValid}, 32'd0);
    check1("R1", "taken", {31'd0, taken}, 32'd0);
    check1("R1", "nextPc", nextPc, 32'd0);
    check1("R1", "illegalCond", {31'd0, illegalCond}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check1("R1", "outValid after release", {31'd0, outValid}, 32'd0);

    // R3: unconditional, flags ignored
    send(7'd25, 4'd3, 32'h1234, 1'b0, 1'b0, 1'b0, 32'h0000_0100, 32'h50, "R3");
    send(7'd25, 4'd0, 32'h0, 1'b1, 1'b1, 1'b1, 32'hDEAD_BEEF, 32'h51, "R3");
    idle(2);

    // R4: register zero test
    send(7'd26, 4'd2, 32'd0, 1'b0, 1'b1, 1'b0, 32'h400, 32'h10, "R4");
    send(7'd26, 4'd2, 32'd5, 1'b1, 1'b0, 1'b0, 32'h400, 32'h11, "R4");
    send(7'd26, 4'd2, 32'h8000_0000, 1'b1, 1'b0, 1'b0, 32'h400, 32'h12, "R4");

    // R5: signed positive
    send(7'd27, 4'd1, 32'd1, 1'b0, 1'b0, 1'b0, 32'h500, 32'h20, "R5");
    send(7'd27, 4'd1, 32'd0, 1'b0, 1'b0, 1'b0, 32'h500, 32'h21, "R5");
    send(7'd27, 4'd1, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 32'h500, 32'h22, "R5");
    send(7'd27, 4'd1, 32'h7FFF_FFFF, 1'b1, 1'b1, 1'b0, 32'h500, 32'h23, "R5");
    send(7'd27, 4'd1, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 32'h500, 32'h24, "R5");
    idle(1);

    // R6: sign bit
    send(7'd28, 4'd9, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 32'h600, 32'h30, "R6");
    send(7'd28, 4'd9, 32'd0, 1'b0, 1'b1, 1'b0, 32'h600, 32'h31, "R6");
    send(7'd28, 4'd9, 32'h7FFF_FFFF, 1'b0, 1'b1, 1'b0, 32'h600, 32'h32, "R6");
    send(7'd28, 4'd9, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 32'h600, 32'h33, "R6");

    // R7..R11: every selector against every flag combination
    for (int s = 0; s < 16; s++) begin
      for (int f = 0; f < 8; f++) begin
        string tag;
        if (s < 2) tag = "R7";
        else if (s < 4) tag = "R8";
        else if (s < 6) tag = "R9";
        else if (s == 6) tag = "R10";
        else tag = "R11";
        send(7'd29, 4'(s), (f[0] ? 32'd0 : 32'hFFFF_FFF0), f[0], f[1], f[2],
             32'h7000 + 32'(s * 8 + f), 32'h1000 + 32'(s * 8 + f), tag);
      end
      if (s % 4 == 3) idle(1);
    end

    // R12: fall-through wrap
    send(7'd26, 4'd0, 32'd7, 1'b0, 1'b0, 1'b0, 32'h123, 32'hFFFF_FFFF, "R12");
    send(7'd29, 4'd1, 32'd0, 1'b1, 1'b0, 1'b0, 32'h123, 32'hFFFF_FFFF, "R12");
    send(7'd25, 4'd0, 32'd0, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0, "R12");

    // R13: non-branch opcodes
    send(7'd24, 4'd0, 32'd0, 1'b1, 1'b1, 1'b1, 32'h900, 32'h40, "R13");
    send(7'd30, 4'd9, 32'd0, 1'b1, 1'b1, 1'b1, 32'h900, 32'h41, "R13");
    send(7'd0,  4'd15, 32'd0, 1'b1, 1'b0, 1'b1, 32'h900, 32'h42, "R13");
    send(7'd127, 4'd7, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 32'h900, 32'h43, "R13");

    idle(4);
    check1("R2", "pending results", 32'(sbQ.size()), 32'd0);
    wrapUp();
  end

endmodule